// File: doc/BRIEF.md
# Segment Identifier Scrambler

This block turns an effective address into a scrambled virtual segment identifier. It first builds a proto-identifier. For kernel addresses that is the segment number of the address. For user addresses it is the context number concatenated with the segment number. A multiplicative hash then scatters the proto-identifier into the identifier space. The hash is taken modulo 2^n−1. No divider is used: the high half of the product is folded onto the low half, and a single end-around correction follows.

Two segment sizes are supported. Small segments are 256 MB and give a 36-bit identifier. Large segments are 1 TB and give a 24-bit identifier. A kernel request names its segment size directly. A user request takes the large size only when its address lies at or above 2^40 and a policy input allows large segments there.

The datapath is a three-stage pipeline: multiply, fold, correct. It sits behind a valid/ready handshake. The whole pipeline advances only while the consumer is ready. The all-ones proto-identifier has no defined scramble, so a request that produces it returns an error flag instead of an identifier.

Top module: `vsid_scrambler`

## Requirements
- R1: A user request on a small segment uses proto = ((ctx << 16) | (ea >> 28)) truncated to 36 bits.
- R2: A user request on a large segment uses proto = ((ctx << 4) | (ea >> 40)) truncated to 24 bits.
- R3: A kernel request uses proto = ea >> 28 (truncated to 36 bits) when `in_kseg_1t` is 0, and ea >> 40 (truncated to 24 bits) when it is 1.
- R4: A user request selects the large segment only when ea[63:40] is nonzero and `in_hi_1t` is 1. Otherwise it selects the small segment.
- R5: For a small segment, `out_vsid` = (proto × 200730139) mod (2^36−1).
- R6: For a large segment, `out_vsid` = (proto × 12538073) mod (2^24−1), and `out_vsid[35:24]` is 0.
- R7: When proto equals 2^n−1 for the chosen segment width n, the result has `out_err` = 1 and `out_vsid` = 0. A non-error result never equals 2^n−1.
- R8: `in_ready` equals `out_ready` once reset is over. With `out_ready` held at 1, a request accepted on one clock edge is presented on `out_valid` after the second following edge, a latency of three edges.
- R9: While `out_ready` is 0, no request is accepted, and `out_valid`, `out_vsid`, `out_err` and `out_seg_1t` hold their values.
- R10: `out_seg_1t` reports the segment size used for the result: 1 for large, 0 for small.
- R11: During reset, and until a request has passed through, `out_valid` and `out_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted on this edge when valid |
| in_ea | input | 64 | Effective address |
| in_ctx | input | 19 | Context number for user requests |
| in_kernel | input | 1 | 1 for a kernel request, 0 for a user request |
| in_kseg_1t | input | 1 | Segment size for kernel requests (1 = 1 TB) |
| in_hi_1t | input | 1 | Policy: user addresses at or above 2^40 use 1 TB segments |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer ready; also the pipeline advance enable |
| out_vsid | output | 36 | Scrambled identifier, zero-extended for 1 TB |
| out_seg_1t | output | 1 | Segment size used for this result |
| out_err | output | 1 | Proto-identifier was the reserved all-ones value |

## Verification
The latency and hold properties assume that the consumer's ready is a free input. They also assume that `in_valid` is low throughout reset, so that the three-edge look-back only ever sees reset-time zeros. The stimulus keeps `in_valid` at 0 until several cycles after reset is released. It then varies valid and ready independently, including long stalls with valid held high. Addresses are drawn both below and above 2^40, with both policy settings and both kernel sizes. This keeps every branch of the segment choice reachable. The reserved all-ones case is reached only through directed addresses, because random values almost never hit it.

// File: rtl/vsid_pkg.sv
package vsid_pkg;

  localparam int unsigned DEF_EA_W     = 64;
  localparam int unsigned DEF_CTX_W    = 19;
  localparam int unsigned DEF_N_SMALL  = 36;
  localparam int unsigned DEF_N_LARGE  = 24;
  localparam int unsigned DEF_SH_SMALL = 28;
  localparam int unsigned DEF_SH_LARGE = 40;
  localparam int unsigned DEF_UE_SMALL = 16;
  localparam int unsigned DEF_UE_LARGE = 4;
  localparam longint unsigned DEF_MUL_SMALL = 64'd200730139;
  localparam longint unsigned DEF_MUL_LARGE = 64'd12538073;

  typedef enum logic {
    SEG_256M = 1'b0,
    SEG_1T   = 1'b1
  } seg_e;

endpackage

// File: rtl/vsid_proto_gen.sv
module vsid_proto_gen
  import vsid_pkg::*;
#(
  parameter int unsigned EA_W     = DEF_EA_W,
  parameter int unsigned CTX_W    = DEF_CTX_W,
  parameter int unsigned N_SMALL  = DEF_N_SMALL,
  parameter int unsigned N_LARGE  = DEF_N_LARGE,
  parameter int unsigned SH_SMALL = DEF_SH_SMALL,
  parameter int unsigned SH_LARGE = DEF_SH_LARGE,
  parameter int unsigned UE_SMALL = DEF_UE_SMALL,
  parameter int unsigned UE_LARGE = DEF_UE_LARGE
) (
  input  logic [EA_W-1:0]    ea,
  input  logic [CTX_W-1:0]   ctx,
  input  logic               kernel,
  input  logic               kseg_1t,
  input  logic               hi_1t,
  output logic [N_SMALL-1:0] proto,
  output seg_e               seg,
  output logic               reserved
);

  localparam int unsigned WIDE_W = EA_W + CTX_W;

  logic [WIDE_W-1:0]  ctx_w;
  logic [WIDE_W-1:0]  ea_w;
  logic               high_region;
  logic [N_SMALL-1:0] cand_small;
  logic [N_LARGE-1:0] cand_large;

  always_comb begin
    ctx_w       = WIDE_W'(ctx);
    ea_w        = WIDE_W'(ea);
    high_region = |ea[EA_W-1:SH_LARGE];

    if (kernel) begin
      seg        = kseg_1t ? SEG_1T : SEG_256M;
      cand_small = N_SMALL'(ea_w >> SH_SMALL);
      cand_large = N_LARGE'(ea_w >> SH_LARGE);
    end else begin
      seg        = (high_region && hi_1t) ? SEG_1T : SEG_256M;
      cand_small = N_SMALL'((ctx_w << UE_SMALL) | (ea_w >> SH_SMALL));
      cand_large = N_LARGE'((ctx_w << UE_LARGE) | (ea_w >> SH_LARGE));
    end

    if (seg == SEG_1T) begin
      proto    = N_SMALL'(cand_large);
      reserved = &cand_large;
    end else begin
      proto    = cand_small;
      reserved = &cand_small;
    end
  end

endmodule

// File: rtl/vsid_fold.sv
module vsid_fold
  import vsid_pkg::*;
#(
  parameter int unsigned PROD_W  = 64,
  parameter int unsigned N_SMALL = DEF_N_SMALL,
  parameter int unsigned N_LARGE = DEF_N_LARGE,
  parameter int unsigned Y_W     = N_SMALL + 1
) (
  input  logic [PROD_W-1:0] x,
  input  seg_e              seg,
  output logic [Y_W-1:0]    y
);

  logic [Y_W-1:0] folded [2];

  for (genvar g = 0; g < 2; g++) begin : g_width
    localparam int unsigned N = (g == 0) ? N_SMALL : N_LARGE;
    assign folded[g] = Y_W'(x >> N) + Y_W'(x[N-1:0]);
  end

  always_comb begin
    y = (seg == SEG_1T) ? folded[1] : folded[0];
  end

endmodule

// File: rtl/vsid_endaround.sv
module vsid_endaround
  import vsid_pkg::*;
#(
  parameter int unsigned N_SMALL = DEF_N_SMALL,
  parameter int unsigned N_LARGE = DEF_N_LARGE,
  parameter int unsigned Y_W     = N_SMALL + 1
) (
  input  logic [Y_W-1:0]     y,
  input  seg_e               seg,
  output logic [N_SMALL-1:0] z
);

  logic [N_SMALL-1:0] fixed [2];

  for (genvar g = 0; g < 2; g++) begin : g_width
    localparam int unsigned N = (g == 0) ? N_SMALL : N_LARGE;
    logic [Y_W-1:0] plus_one;
    logic [Y_W-1:0] sum;
    assign plus_one = y + Y_W'(1);
    assign sum      = y + Y_W'(plus_one[N]);
    assign fixed[g] = N_SMALL'(sum[N-1:0]);
  end

  always_comb begin
    z = (seg == SEG_1T) ? fixed[1] : fixed[0];
  end

endmodule

// File: rtl/vsid_scrambler.sv
module vsid_scrambler
  import vsid_pkg::*;
#(
  parameter int unsigned EA_W     = DEF_EA_W,
  parameter int unsigned CTX_W    = DEF_CTX_W,
  parameter int unsigned N_SMALL  = DEF_N_SMALL,
  parameter int unsigned N_LARGE  = DEF_N_LARGE,
  parameter int unsigned SH_SMALL = DEF_SH_SMALL,
  parameter int unsigned SH_LARGE = DEF_SH_LARGE,
  parameter int unsigned UE_SMALL = DEF_UE_SMALL,
  parameter int unsigned UE_LARGE = DEF_UE_LARGE,
  parameter longint unsigned MUL_SMALL = DEF_MUL_SMALL,
  parameter longint unsigned MUL_LARGE = DEF_MUL_LARGE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [EA_W-1:0]    in_ea,
  input  logic [CTX_W-1:0]   in_ctx,
  input  logic               in_kernel,
  input  logic               in_kseg_1t,
  input  logic               in_hi_1t,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [N_SMALL-1:0] out_vsid,
  output logic               out_seg_1t,
  output logic               out_err
);

  localparam int unsigned MUL_W  = $clog2(MUL_SMALL + 1);
  localparam int unsigned PROD_W = N_SMALL + MUL_W;
  localparam int unsigned Y_W    = N_SMALL + 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic advance;
  logic accept;

  always_comb begin
    advance  = out_ready;
    in_ready = out_ready & rst_sync_n;
    accept   = in_valid & in_ready;
  end

  // stage 0 combinational: proto-identifier and multiply
  logic [N_SMALL-1:0] proto;
  seg_e               seg0;
  logic               rsv0;
  logic [MUL_W-1:0]   mul_sel;
  logic [PROD_W-1:0]  prod0;

  vsid_proto_gen #(
    .EA_W(EA_W), .CTX_W(CTX_W), .N_SMALL(N_SMALL), .N_LARGE(N_LARGE),
    .SH_SMALL(SH_SMALL), .SH_LARGE(SH_LARGE),
    .UE_SMALL(UE_SMALL), .UE_LARGE(UE_LARGE)
  ) u_proto (
    .ea(in_ea), .ctx(in_ctx), .kernel(in_kernel), .kseg_1t(in_kseg_1t),
    .hi_1t(in_hi_1t), .proto(proto), .seg(seg0), .reserved(rsv0)
  );

  always_comb begin
    mul_sel = (seg0 == SEG_1T) ? MUL_W'(MUL_LARGE) : MUL_W'(MUL_SMALL);
    prod0   = PROD_W'(proto) * PROD_W'(mul_sel);
  end

  // stage 1 registers: product
  logic              v1_q, v1_d;
  logic              e1_q, e1_d;
  seg_e              s1_q, s1_d;
  logic [PROD_W-1:0] x1_q, x1_d;

  always_comb begin
    v1_d = v1_q;
    e1_d = e1_q;
    s1_d = s1_q;
    x1_d = x1_q;
    if (advance) begin
      v1_d = accept;
      e1_d = accept & rsv0;
      s1_d = seg0;
      x1_d = prod0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v1_q <= 1'b0;
      e1_q <= 1'b0;
      s1_q <= SEG_256M;
    end else begin
      v1_q <= v1_d;
      e1_q <= e1_d;
      s1_q <= s1_d;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) x1_q <= x1_d;
  end

  // stage 2: fold high part onto low part
  logic [Y_W-1:0] y2_comb;

  vsid_fold #(
    .PROD_W(PROD_W), .N_SMALL(N_SMALL), .N_LARGE(N_LARGE), .Y_W(Y_W)
  ) u_fold (
    .x(x1_q), .seg(s1_q), .y(y2_comb)
  );

  logic           v2_q, v2_d;
  logic           e2_q, e2_d;
  seg_e           s2_q, s2_d;
  logic [Y_W-1:0] y2_q, y2_d;

  always_comb begin
    v2_d = v2_q;
    e2_d = e2_q;
    s2_d = s2_q;
    y2_d = y2_q;
    if (advance) begin
      v2_d = v1_q;
      e2_d = e1_q;
      s2_d = s1_q;
      y2_d = y2_comb;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v2_q <= 1'b0;
      e2_q <= 1'b0;
      s2_q <= SEG_256M;
    end else begin
      v2_q <= v2_d;
      e2_q <= e2_d;
      s2_q <= s2_d;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) y2_q <= y2_d;
  end

  // stage 3: end-around correction
  logic [N_SMALL-1:0] z3_comb;

  vsid_endaround #(
    .N_SMALL(N_SMALL), .N_LARGE(N_LARGE), .Y_W(Y_W)
  ) u_fix (
    .y(y2_q), .seg(s2_q), .z(z3_comb)
  );

  logic               v3_q, v3_d;
  logic               e3_q, e3_d;
  seg_e               s3_q, s3_d;
  logic [N_SMALL-1:0] z3_q, z3_d;

  always_comb begin
    v3_d = v3_q;
    e3_d = e3_q;
    s3_d = s3_q;
    z3_d = z3_q;
    if (advance) begin
      v3_d = v2_q;
      e3_d = e2_q;
      s3_d = s2_q;
      z3_d = e2_q ? '0 : z3_comb;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v3_q <= 1'b0;
      e3_q <= 1'b0;
      s3_q <= SEG_256M;
    end else begin
      v3_q <= v3_d;
      e3_q <= e3_d;
      s3_q <= s3_d;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) z3_q <= z3_d;
  end

  always_comb begin
    out_valid  = v3_q;
    out_err    = e3_q;
    out_seg_1t = (s3_q == SEG_1T);
    out_vsid   = z3_q;
  end

endmodule

// File: rtl/vsid_scrambler_chk.sv
module vsid_scrambler_chk #(
  parameter int unsigned N_SMALL = 36,
  parameter int unsigned N_LARGE = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [N_SMALL-1:0] out_vsid,
  input logic               out_seg_1t,
  input logic               out_err
);

  // R9: a stalled result stays put
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_vsid) && $stable(out_err) && $stable(out_seg_1t)));

  // R9: nothing is taken in while the consumer stalls
  assert_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready);

  // R8: fixed three-edge latency while ready stays high
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 3) && $past(out_ready, 1) && $past(out_ready, 2))
      |-> out_valid);

  // R7: an error result carries a zero identifier
  assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_vsid == '0));

  // R6: large-segment identifiers fit in the narrow width
  assert_large_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_seg_1t) |-> (out_vsid[N_SMALL-1:N_LARGE] == '0));

  // R7: a good result never lands on the reserved all-ones value
  assert_not_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |->
      (out_seg_1t ? (out_vsid[N_LARGE-1:0] != '1) : (out_vsid != '1)));

endmodule

bind vsid_scrambler vsid_scrambler_chk #(
  .N_SMALL(N_SMALL), .N_LARGE(N_LARGE)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_vsid(out_vsid),
  .out_seg_1t(out_seg_1t), .out_err(out_err)
);

// File: tb/tb_vsid_scrambler.sv
`timescale 1ns/1ps
module tb_vsid_scrambler;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_ea;
  logic [18:0] in_ctx;
  logic        in_kernel;
  logic        in_kseg_1t;
  logic        in_hi_1t;
  logic        out_valid;
  logic        out_ready;
  logic [35:0] out_vsid;
  logic        out_seg_1t;
  logic        out_err;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;

  logic [37:0] exp_q[$];
  string       tag_q[$];

  vsid_scrambler dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ea(in_ea), .in_ctx(in_ctx), .in_kernel(in_kernel),
    .in_kseg_1t(in_kseg_1t), .in_hi_1t(in_hi_1t), .out_valid(out_valid),
    .out_ready(out_ready), .out_vsid(out_vsid), .out_seg_1t(out_seg_1t),
    .out_err(out_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // packed result: [37]=err [36]=large segment [35:0]=identifier
  function automatic logic [37:0] model(input logic [63:0] ea, input logic [18:0] ctx,
                                        input bit kern, input bit kseg, input bit pol);
    bit seg;
    longint unsigned p, m, md, r;
    seg = kern ? kseg : ((ea >> 40) != 0 && pol);
    if (!seg) begin
      md = (64'd1 << 36) - 1;
      m  = 64'd200730139;
      p  = kern ? (ea >> 28) : ((64'(ctx) << 16) | (ea >> 28));
    end else begin
      md = (64'd1 << 24) - 1;
      m  = 64'd12538073;
      p  = kern ? (ea >> 40) : ((64'(ctx) << 4) | (ea >> 40));
    end
    p = p & md;
    if (p == md) return {1'b1, seg, 36'd0};
    r = (p * m) % md;
    return {1'b0, seg, r[35:0]};
  endfunction

  task automatic step(input bit iv, input bit ordy, input logic [63:0] ea,
                      input logic [18:0] ctx, input bit kern, input bit kseg,
                      input bit pol, input string tag);
    logic [37:0] e;
    string t;
    if (out_valid && ordy) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", {27'd0, out_err, out_vsid}, 64'd0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_vsid == e[35:0] && out_err == e[37], t,
              {27'd0, out_err, out_vsid}, {27'd0, e[37], e[35:0]});
        check(out_seg_1t == e[36], "R10", 64'(out_seg_1t), 64'(e[36]));
      end
    end
    in_valid   = iv;
    out_ready  = ordy;
    in_ea      = ea;
    in_ctx     = ctx;
    in_kernel  = kern;
    in_kseg_1t = kseg;
    in_hi_1t   = pol;
    if (iv && ordy) begin
      exp_q.push_back(model(ea, ctx, kern, kseg, pol));
      tag_q.push_back(tag);
    end
    @(negedge clk);
  endtask

  task automatic idle(input bit ordy);
    step(1'b0, ordy, 64'd0, 19'd0, 1'b0, 1'b0, 1'b0, "R8");
  endtask

  function automatic logic [63:0] rnd_ea();
    logic [63:0] v;
    v = {$urandom, $urandom};
    if ($urandom_range(0, 1) == 0) v = v & 64'h0000_00FF_FFFF_FFFF;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [35:0] held;
    bit          held_seg;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_ea = '0; in_ctx = '0;
    in_kernel = 1'b0; in_kseg_1t = 1'b0; in_hi_1t = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R11", 64'(out_valid), 64'd0);
    check(out_err == 1'b0, "R11", 64'(out_err), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R11", 64'(out_valid), 64'd0);

    // directed requests
    step(1, 1, 64'h0000_0012_3456_7890, 19'h5A5A5, 0, 0, 1, "R1");
    step(1, 1, 64'h0000_00FF_F000_0000, 19'h7FFFF, 0, 0, 0, "R1");
    step(1, 1, 64'h0000_0A00_0000_0000, 19'h12345, 0, 0, 1, "R2");
    step(1, 1, 64'h0000_0A00_0000_0000, 19'h12345, 0, 0, 0, "R4");
    step(1, 1, 64'h0000_00FF_FFFF_FFFF, 19'h00001, 0, 0, 1, "R4");
    step(1, 1, 64'hC000_0000_1000_0000, 19'h00000, 1, 0, 0, "R3");
    step(1, 1, 64'hC000_0100_0000_0000, 19'h00000, 1, 1, 0, "R3");
    step(1, 1, 64'hFFFF_FFFF_F000_0000, 19'h00000, 1, 0, 0, "R7");
    step(1, 1, 64'hFFFF_FF00_0000_0000, 19'h00000, 1, 1, 1, "R7");
    step(1, 1, 64'hFFFF_FFF0_0000_0000, 19'h7FFFF, 0, 0, 1, "R7");
    step(1, 1, 64'h0000_0000_1000_0000, 19'h00000, 1, 0, 0, "R5");
    step(1, 1, 64'h0000_0100_0000_0000, 19'h00000, 1, 1, 0, "R6");
    repeat (5) idle(1);

    // latency with ready held high
    step(1, 1, 64'hC123_4567_89AB_CDEF, 19'h0, 1, 0, 0, "R8");
    check(out_valid == 1'b0, "R8", 64'(out_valid), 64'd0);
    idle(1);
    check(out_valid == 1'b0, "R8", 64'(out_valid), 64'd0);
    idle(1);
    check(out_valid == 1'b1, "R8", 64'(out_valid), 64'd1);
    repeat (4) idle(1);

    // random traffic with random back-pressure
    for (int i = 0; i < 600; i++) begin
      bit kern;
      kern = ($urandom_range(0, 3) == 0);
      step($urandom_range(0, 9) < 7, $urandom_range(0, 3) != 0, rnd_ea(),
           19'($urandom), kern, 1'($urandom), 1'($urandom), kern ? "R3" : "R5");
    end
    repeat (5) idle(1);

    // long stall with valid held high
    for (int i = 0; i < 3; i++)
      step(1, 1, rnd_ea(), 19'($urandom), 0, 0, 1, "R9");
    held     = out_vsid;
    held_seg = out_seg_1t;
    for (int i = 0; i < 4; i++) begin
      step(1, 0, rnd_ea(), 19'($urandom), 1, 1, 0, "R9");
      check(out_valid == 1'b1, "R9", 64'(out_valid), 64'd1);
      check(out_vsid == held && out_seg_1t == held_seg, "R9",
            64'(out_vsid), 64'(held));
      check(in_ready == 1'b0, "R8", 64'(in_ready), 64'd0);
    end
    repeat (6) idle(1);
    check(exp_q.size() == 0, "R9", 64'(exp_q.size()), 64'd0);
    check(out_valid == 1'b0, "R8", 64'(out_valid), 64'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule